// File: doc/BRIEF.md
# Seven-Slot Three-Lane Pixel Deserializer

This block rebuilds one parallel pixel word from three serial data lanes and a forwarded clock lane. Every lane carries seven bit slots per pixel period. One sample of each lane is taken on each edge of a supplied sampling clock that runs seven times faster than the pixel rate. The forwarded clock lane repeats a fixed seven-slot high/low shape. Finding that shape in the incoming stream marks where each pixel frame ends, so no coding on the data lanes is needed for alignment.

Once the block has seen the shape at two frame ends in a row, it declares lock. From then on it presents each new 21-bit word with a one-cycle valid strobe. It also regenerates a pixel clock whose rising edge falls in the middle of the time each word is held. The 21 bits hold 18 colour bits and three panel timing bits (line sync, frame sync, data ready). The block passes them through as data. A power-down input forces every output to zero and drops lock.

Top module: `px7_deser`

## Requirements
- R1: While reset is asserted, and right after it is released, px_word_o, px_valid_o, px_clk_o and locked_o are all zero.
- R2: Lane k at slot s (s = 0 is the first bit of a frame in time) lands in word bit 7*k + s. Lane 0 fills bits 0..6, lane 1 fills bits 7..13 and lane 2 fills bits 14..20.
- R3: A frame end is the edge at which the last seven clock-lane samples, in time order, are 1,1,0,0,0,1,1. While unlocked, locked_o rises on the edge that samples the last slot of the second such frame in a row, seven edges after the first. No word is presented on that edge.
- R4: While locked, px_valid_o is high for exactly one cycle, on the edge that samples slot 6 of each frame whose clock pattern matches. The first word therefore comes from the third matching frame in a row.
- R5: px_word_o changes only on an edge where px_valid_o is set, or when power-down clears it. At all other times, including mid-frame, it holds its last value.
- R6: While locked, a frame end whose clock pattern does not match clears locked_o on that edge. That edge gives no strobe and the word is held. Lock then needs two new matching frames in a row.
- R7: While locked, px_clk_o is high after the edges that sample slots 2, 3, 4 and 5 and low after slots 6, 0 and 1. It is low whenever the block is unlocked.
- R8: On every edge with pwr_dn_i high, all outputs go to zero and lock and any partial alignment are cleared. After release, lock again needs two matching frames.
- R9: Alignment works at any slot phase. Any number of idle clock-lane zeros before the first frame does not prevent lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot sampling clock, seven times the pixel rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_dn_i | input | 1 | Power-down: outputs zero, lock cleared |
| clk_lane_i | input | 1 | Forwarded clock lane sample |
| data_lane_i | input | 3 | Data lane samples, bit k is lane k |
| px_word_o | output | 21 | Reassembled pixel word |
| px_valid_o | output | 1 | One-cycle strobe for a new word |
| px_clk_o | output | 1 | Regenerated pixel clock |
| locked_o | output | 1 | Frame alignment held |

## Verification
Every result is registered on the same edge that samples the slot completing it. A new word, the strobe, a change in lock and the end of power-down are all visible one clock after the last relevant input was driven. The bench drives each slot on a falling edge and reads the outputs on the next falling edge. It records the lock state, strobe and word after slot 6 of every frame. It also records the regenerated clock after every slot and the word after slot 3, so the mid-frame hold and the clock shape are checked at their exact cycles. Power-down is checked one edge after it is raised.

// File: rtl/px7_pkg.sv
package px7_pkg;
    localparam int LANE_CNT  = 3;
    localparam int SLOT_CNT  = 7;
    // Clock-lane shape; bit 0 is the earliest slot of the frame.
    localparam logic [SLOT_CNT-1:0] FRAME_PAT = 7'b1100011;
endpackage

// File: rtl/px7_slot_shift.sv
module px7_slot_shift #(
    parameter int SLOTS = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             bit_i,
    output logic [SLOTS-1:0] win_o
);
    logic [SLOTS-1:0] sr_d, sr_q;

    // Newest sample enters at the top; bit 0 holds the oldest of the window.
    always_comb begin
        win_o = {bit_i, sr_q[SLOTS-1:1]};
        sr_d  = clr ? '0 : win_o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_d;
    end
endmodule

// File: rtl/px7_frame_align.sv
module px7_frame_align #(
    parameter int SLOTS = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_dn,
    input  logic hit,
    output logic fire_o,
    output logic lock_o,
    output logic pclk_o
);
    localparam int CNT_W = $clog2(SLOTS);
    localparam logic [CNT_W-1:0] LAST    = CNT_W'(SLOTS - 1);
    localparam logic [CNT_W-1:0] HI_FROM = CNT_W'(SLOTS / 2);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             armed;
        logic             lock;
        logic             pclk;
    } algn_t;

    algn_t st_d, st_q;
    logic  at_end;

    always_comb begin
        st_d   = st_q;
        fire_o = 1'b0;
        at_end = (st_q.cnt == LAST);
        st_d.cnt = at_end ? '0 : st_q.cnt + CNT_W'(1);
        if (pwr_dn) begin
            st_d = '0;
        end else if (st_q.lock) begin
            if (at_end) begin
                if (hit) begin
                    fire_o = 1'b1;
                end else begin
                    st_d.lock  = 1'b0;
                    st_d.armed = 1'b0;
                end
            end
        end else if (hit) begin
            st_d.cnt = '0;
            if (st_q.armed && at_end) begin
                st_d.lock  = 1'b1;
                st_d.armed = 1'b0;
            end else begin
                st_d.armed = 1'b1;
            end
        end else if (at_end) begin
            st_d.armed = 1'b0;
        end
        st_d.pclk = st_d.lock && (st_d.cnt >= HI_FROM);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lock_o = st_q.lock;
    assign pclk_o = st_q.pclk;
endmodule

// File: rtl/px7_deser.sv
module px7_deser #(
    parameter int LANES = px7_pkg::LANE_CNT,
    parameter int SLOTS = px7_pkg::SLOT_CNT,
    parameter logic [SLOTS-1:0] CLK_PAT = px7_pkg::FRAME_PAT
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   pwr_dn_i,
    input  logic                   clk_lane_i,
    input  logic [LANES-1:0]       data_lane_i,
    output logic [LANES*SLOTS-1:0] px_word_o,
    output logic                   px_valid_o,
    output logic                   px_clk_o,
    output logic                   locked_o
);
    localparam int WORD = LANES * SLOTS;

    typedef struct packed {
        logic [WORD-1:0] word;
        logic            valid;
    } out_t;

    logic [SLOTS-1:0] clk_win;
    logic [WORD-1:0]  word_win;
    logic             hit, fire;
    out_t             o_d, o_q;

    px7_slot_shift #(.SLOTS(SLOTS)) u_clk_sr (
        .clk(clk), .rst_n(rst_n), .clr(pwr_dn_i),
        .bit_i(clk_lane_i), .win_o(clk_win)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        px7_slot_shift #(.SLOTS(SLOTS)) u_sr (
            .clk(clk), .rst_n(rst_n), .clr(pwr_dn_i),
            .bit_i(data_lane_i[k]), .win_o(word_win[k*SLOTS +: SLOTS])
        );
    end

    assign hit = (clk_win == CLK_PAT);

    px7_frame_align #(.SLOTS(SLOTS)) u_align (
        .clk(clk), .rst_n(rst_n), .pwr_dn(pwr_dn_i), .hit(hit),
        .fire_o(fire), .lock_o(locked_o), .pclk_o(px_clk_o)
    );

    always_comb begin
        o_d       = o_q;
        o_d.valid = fire;
        if (fire)     o_d.word = word_win;
        if (pwr_dn_i) o_d      = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign px_word_o  = o_q.word;
    assign px_valid_o = o_q.valid;
endmodule

// File: rtl/px7_deser_chk.sv
module px7_deser_chk #(
    parameter int WORD = 21
) (
    input logic            clk,
    input logic            rst_n,
    input logic            pwr_dn,
    input logic [WORD-1:0] px_word,
    input logic            px_valid,
    input logic            px_clk,
    input logic            locked
);
    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (px_word == '0 && !px_valid && !px_clk && !locked));

    assert_no_word_on_lock_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> !px_valid);

    assert_valid_needs_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
        px_valid |-> locked);

    assert_single_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        px_valid |=> !px_valid);

    assert_word_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!px_valid && !$past(pwr_dn)) |-> $stable(px_word));

    assert_loss_no_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(locked) |-> !px_valid);

    assert_pclk_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        px_clk |-> locked);

    assert_pdn_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_dn |=> (px_word == '0 && !px_valid && !px_clk && !locked));
endmodule

bind px7_deser px7_deser_chk #(.WORD(WORD)) u_chk (
    .clk(clk), .rst_n(rst_n), .pwr_dn(pwr_dn_i), .px_word(px_word_o),
    .px_valid(px_valid_o), .px_clk(px_clk_o), .locked(locked_o)
);

// File: tb/sim_px7_deser.sv
`timescale 1ns/1ps
module sim_px7_deser;
    localparam logic [6:0] PAT = 7'b1100011;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwr_dn_i = 1'b0;
    logic        clk_lane_i = 1'b0;
    logic [2:0]  data_lane_i = '0;
    logic [20:0] px_word_o;
    logic        px_valid_o, px_clk_o, locked_o;

    int checks = 0;
    int failures = 0;

    // bench model
    logic        m_armed = 1'b0, m_lock = 1'b0;
    logic [20:0] m_word = '0;

    always #2 clk = ~clk;

    px7_deser u0 (
        .clk(clk), .rst_n(rst_n), .pwr_dn_i(pwr_dn_i), .clk_lane_i(clk_lane_i),
        .data_lane_i(data_lane_i), .px_word_o(px_word_o), .px_valid_o(px_valid_o),
        .px_clk_o(px_clk_o), .locked_o(locked_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic logic [6:0] exp_pclk(input logic lock_start);
        return lock_start ? 7'b0111100 : 7'b0000000;
    endfunction

    task automatic idle_slots(input int n);
        for (int i = 0; i < n; i++) begin
            clk_lane_i = 1'b0;
            data_lane_i = 3'($urandom);
            @(negedge clk);
        end
    endtask

    // Drives one seven-slot frame and checks every output at its due cycle.
    task automatic frame(input logic [6:0] cpat, input logic [20:0] dat);
        logic [6:0]  trace;
        logic [20:0] mid, prev;
        logic        lock_start, good, exp_valid;
        lock_start = m_lock;
        prev = m_word;
        for (int s = 0; s < 7; s++) begin
            clk_lane_i = cpat[s];
            for (int k = 0; k < 3; k++) data_lane_i[k] = dat[7*k + s];
            @(negedge clk);
            trace[s] = px_clk_o;
            if (s == 3) mid = px_word_o;
        end
        good = (cpat == PAT);
        exp_valid = good && m_lock;
        if (good) begin
            if (m_lock) m_word = dat;
            else if (m_armed) begin m_lock = 1'b1; m_armed = 1'b0; end
            else m_armed = 1'b1;
        end else begin
            m_lock = 1'b0;
            m_armed = 1'b0;
        end
        chk("R4 strobe", 32'(px_valid_o), 32'(exp_valid));
        chk(good ? "R3 lock" : "R6 lock loss", 32'(locked_o), 32'(m_lock));
        chk("R2 word", 32'(px_word_o), 32'(m_word));
        chk("R5 mid-frame hold", 32'(mid), 32'(prev));
        chk("R7 pixel clock", 32'(trace), 32'(exp_pclk(lock_start)));
    endtask

    task automatic power_down(input int n);
        pwr_dn_i = 1'b1;
        clk_lane_i = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk("R8 quiet", {px_word_o, px_valid_o, px_clk_o, locked_o}, 32'h0);
        end
        pwr_dn_i = 1'b0;
        m_armed = 1'b0;
        m_lock = 1'b0;
        m_word = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog act=running exp=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0007));
        repeat (3) @(negedge clk);
        chk("R1 in reset", {px_word_o, px_valid_o, px_clk_o, locked_o}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", {px_word_o, px_valid_o, px_clk_o, locked_o}, 32'h0);

        // R9: odd phase before the first frame
        idle_slots(3);
        frame(PAT, 21'h0ABCDE);
        frame(PAT, 21'h012345);
        // R2: walking one through every lane and slot
        for (int i = 0; i < 21; i++) frame(PAT, 21'(1) << i);
        frame(PAT, 21'h1FFFFF);
        frame(PAT, 21'h155555);
        // R6: broken pattern, then relock
        frame(7'b0000000, 21'h1F0F0F);
        frame(PAT, 21'h0AAAAA);
        frame(PAT, 21'h055555);
        frame(PAT, 21'h13579B);
        frame(7'b1111111, 21'h000000);
        // R8: power-down while locked, then relock
        frame(PAT, 21'h0F0F0F);
        frame(PAT, 21'h070707);
        frame(PAT, 21'h1C1C1C);
        power_down(3);
        idle_slots(5);
        frame(PAT, 21'h111111);
        frame(PAT, 21'h022222);
        frame(PAT, 21'h033333);

        // random stream with occasional faults and power-downs
        for (int f = 0; f < 400; f++) begin
            int r;
            r = int'($urandom % 40);
            if (r == 0) begin
                power_down(int'($urandom % 3) + 1);
                idle_slots(int'($urandom % 7));
            end else if (r < 5) begin
                frame(($urandom % 2) ? 7'b1111111 : 7'b0000000, 21'($urandom));
            end else begin
                frame(PAT, 21'($urandom));
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule